// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns the three nanosecond figures of a programmed-I/O transfer mode (address setup time, strobe active time and full cycle time) into the clock counts that a drive timing generator is loaded with. The host clock period is given in nanoseconds. Each count is a round-up division, done one after another on a single shared shift-and-subtract divider. The raw counts then go through the generator's limits. The active count has a floor. The recovery count is the larger of two derived values, and any recovery beyond the generator's reach is moved into the active count. A revision-dependent one-clock recovery offset is applied before the final cap.

A calculation starts with a one-cycle `start` pulse while the block is idle. The block raises `done` for one cycle when its registered outputs are valid, and those outputs hold until the next `done`. Two drives on one channel may share one register set. For that case, a merge input makes every field take the slower of this drive's counts and the partner drive's counts. The outputs are ready to write: a 2-bit setup code, and a byte with the active count in the high nibble and the recovery count in the low nibble. The requested mode number is also returned, limited to the highest mode the table holds.

Top module: `pio_count_calc`

## Requirements
- R1: A `start` seen while `busy` is low captures all inputs, and `busy` is high from the next cycle until `done`. `done` lasts exactly one cycle. A `start` or an input change while `busy` is high has no effect on the result.
- R2: `setup_cnt` = ceil(setup_ns / clk_period_ns), saturated at 2^SET_W-1 (15 by default). A time of 0 gives 0.
- R3: The active count is ceil(active_ns / clk_period_ns), raised to at least 2.
- R4: Recovery time is cycle_ns minus (setup_ns + active_ns), taken as 0 when negative. The recovery count is the larger of ceil(recovery time / period) and (cycle count − setup count − active count, taken as 0 when negative), then raised to at least 2.
- R5: If that recovery count exceeds 17, the excess is added to the active count and recovery becomes 17. `active_cnt` is then capped at 16.
- R6: When `chip_rev` is 2 or 3, one is subtracted from the recovery count. For any revision, the result is then capped at 16 to give `recovery_cnt`.
- R7: With `merge_en` high, `setup_cnt`, `active_cnt` and `recovery_cnt` each take the larger of the computed value and the matching partner input.
- R8: `setup_code` encodes the final setup count as follows: 1 or 2 gives 2'b01, 3 gives 2'b10, 4 gives 2'b00, and any other value (0 or 5 and above) gives 2'b11.
- R9: `timing_byte` = {active_cnt[3:0], recovery_cnt[3:0]}, so a count of 16 is written as a nibble of 0.
- R10: `mode_eff` equals `mode_req` captured at start, clamped to 5 when above 5.
- R11: After reset `busy`, `done` and all count and code outputs are 0. Outputs change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a calculation |
| mode_req | input | 3 | Requested transfer mode number |
| setup_ns | input | TIME_W | Address setup time in ns |
| active_ns | input | TIME_W | Strobe active time in ns |
| cycle_ns | input | TIME_W | Total cycle time in ns |
| clk_period_ns | input | CLK_W | Host clock period in ns, nonzero |
| chip_rev | input | 2 | Timing generator revision |
| merge_en | input | 1 | Merge with the partner drive's counts |
| mate_setup | input | SET_W | Partner setup count |
| mate_active | input | 5 | Partner active count (1..16) |
| mate_recovery | input | 5 | Partner recovery count (1..16) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: outputs valid |
| mode_eff | output | 3 | Clamped mode number |
| setup_cnt | output | SET_W | Final setup count |
| active_cnt | output | 5 | Final active count |
| recovery_cnt | output | 5 | Final recovery count |
| setup_code | output | 2 | Encoded setup count |
| timing_byte | output | 8 | Packed active/recovery nibbles |

## Verification
The checks assume that `clk_period_ns` is never zero when a calculation is accepted, because a zero divisor has no meaningful round-up. They also assume that the partner active and recovery counts are already legal generator values from 1 to 16, so the merged fields stay inside the ranges the properties claim. The stimulus draws periods from 1 to 60 ns and partner counts from 1 to 16 only. Times range up to the full input width, so recovery spill, negative recovery time and saturated setup counts all occur.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_FIN  = 2'd2
    } calc_state_e;

    // Order in which the four round-up divisions run.
    localparam logic [1:0] SLOT_CYC = 2'd0;
    localparam logic [1:0] SLOT_SET = 2'd1;
    localparam logic [1:0] SLOT_ACT = 2'd2;
    localparam logic [1:0] SLOT_REC = 2'd3;

    // Generator limits.
    localparam int ACT_FLOOR  = 2;
    localparam int REC_FLOOR  = 2;
    localparam int REC_SPILL  = 17;
    localparam int FIELD_CAP  = 16;
    localparam int MODE_TOP   = 5;

    function automatic logic [1:0] setup_code_f(input int unsigned clocks);
        logic [1:0] c;
        case (clocks)
            1, 2:    c = 2'b01;
            3:       c = 2'b10;
            4:       c = 2'b00;
            default: c = 2'b11;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             valid,
    output logic [NUM_W-1:0] quot
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           take;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        trial   = {q.rem, q.quo[NUM_W-1]};
        diff    = trial - {1'b0, q.den};
        take    = (trial >= {1'b0, q.den});
        if (go) begin
            d.run = 1'b1;
            d.cnt = CNT_W'(NUM_W);
            d.den = den;
            d.rem = '0;
            // Adding (den - 1) turns the floor division into a round-up.
            d.quo = num + {{(NUM_W-DEN_W){1'b0}}, den} - NUM_W'(1);
        end else if (q.run) begin
            d.rem = take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            d.quo = {q.quo[NUM_W-2:0], take};
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.run   = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.valid;
    assign quot  = q.quo;

endmodule

// File: rtl/pio_count_limits.sv
module pio_count_limits #(
    parameter int Q_W   = 12,
    parameter int SET_W = 4
) (
    input  logic [Q_W-1:0]   cyc_q,
    input  logic [Q_W-1:0]   set_q,
    input  logic [Q_W-1:0]   act_q,
    input  logic [Q_W-1:0]   rec_q,
    input  logic             rev_hi,
    output logic [SET_W-1:0] set_fin,
    output logic [4:0]       act_fin,
    output logic [4:0]       rec_fin
);
    import pio_calc_pkg::*;

    localparam int W = Q_W + 2;
    localparam logic signed [W-1:0] K_ZERO  = '0;
    localparam logic signed [W-1:0] K_ONE   = W'(1);
    localparam logic signed [W-1:0] K_AFL   = W'(ACT_FLOOR);
    localparam logic signed [W-1:0] K_RFL   = W'(REC_FLOOR);
    localparam logic signed [W-1:0] K_SPILL = W'(REC_SPILL);
    localparam logic signed [W-1:0] K_CAP   = W'(FIELD_CAP);

    logic signed [W-1:0] cyc_s, set_s, act_s, rec_s;
    logic signed [W-1:0] act1, gap, rec1, act2, rec2, rec3;

    always_comb begin
        cyc_s = $signed({2'b00, cyc_q});
        set_s = $signed({2'b00, set_q});
        act_s = $signed({2'b00, act_q});
        rec_s = $signed({2'b00, rec_q});

        act1 = (act_s < K_AFL) ? K_AFL : act_s;

        gap = cyc_s - set_s - act1;
        if (gap < K_ZERO) gap = K_ZERO;

        rec1 = (rec_s > gap) ? rec_s : gap;
        if (rec1 < K_RFL) rec1 = K_RFL;

        if (rec1 > K_SPILL) begin
            act2 = act1 + (rec1 - K_SPILL);
            rec2 = K_SPILL;
        end else begin
            act2 = act1;
            rec2 = rec1;
        end
        if (act2 > K_CAP) act2 = K_CAP;

        rec3 = rev_hi ? (rec2 - K_ONE) : rec2;
        if (rec3 > K_CAP) rec3 = K_CAP;

        act_fin = act2[4:0];
        rec_fin = rec3[4:0];
    end

    generate
        if (SET_W >= Q_W) begin : g_set_wide
            assign set_fin = SET_W'(set_q);
        end else begin : g_set_sat
            localparam logic [Q_W-1:0] SET_MAX = Q_W'((1 << SET_W) - 1);
            assign set_fin = (set_q > SET_MAX) ? {SET_W{1'b1}} : set_q[SET_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pio_count_pack.sv
module pio_count_pack #(
    parameter int SET_W = 4
) (
    input  logic [SET_W-1:0] own_set,
    input  logic [4:0]       own_act,
    input  logic [4:0]       own_rec,
    input  logic             mrg,
    input  logic [SET_W-1:0] mate_set,
    input  logic [4:0]       mate_act,
    input  logic [4:0]       mate_rec,
    output logic [SET_W-1:0] set_out,
    output logic [4:0]       act_out,
    output logic [4:0]       rec_out,
    output logic [1:0]       code_out,
    output logic [7:0]       byte_out
);
    import pio_calc_pkg::*;

    always_comb begin
        set_out = own_set;
        act_out = own_act;
        rec_out = own_rec;
        if (mrg) begin
            if (mate_set > set_out) set_out = mate_set;
            if (mate_act > act_out) act_out = mate_act;
            if (mate_rec > rec_out) rec_out = mate_rec;
        end
        code_out = setup_code_f(32'(set_out));
        byte_out = {act_out[3:0], rec_out[3:0]};
    end

endmodule

// File: rtl/pio_count_calc.sv
module pio_count_calc #(
    parameter int TIME_W = 11,
    parameter int CLK_W  = 8,
    parameter int SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode_req,
    input  logic [TIME_W-1:0] setup_ns,
    input  logic [TIME_W-1:0] active_ns,
    input  logic [TIME_W-1:0] cycle_ns,
    input  logic [CLK_W-1:0]  clk_period_ns,
    input  logic [1:0]        chip_rev,
    input  logic              merge_en,
    input  logic [SET_W-1:0]  mate_setup,
    input  logic [4:0]        mate_active,
    input  logic [4:0]        mate_recovery,
    output logic              busy,
    output logic              done,
    output logic [2:0]        mode_eff,
    output logic [SET_W-1:0]  setup_cnt,
    output logic [4:0]        active_cnt,
    output logic [4:0]        recovery_cnt,
    output logic [1:0]        setup_code,
    output logic [7:0]        timing_byte
);
    import pio_calc_pkg::*;

    localparam int NUM_W = ((TIME_W > CLK_W) ? TIME_W : CLK_W) + 1;
    localparam int EXT_W = NUM_W - TIME_W;

    typedef struct packed {
        calc_state_e        state;
        logic [1:0]         slot;
        logic               go;
        logic [TIME_W-1:0]  set_ns;
        logic [TIME_W-1:0]  act_ns;
        logic [TIME_W-1:0]  cyc_ns;
        logic [CLK_W-1:0]   per;
        logic               rev_hi;
        logic               mrg;
        logic [SET_W-1:0]   m_set;
        logic [4:0]         m_act;
        logic [4:0]         m_rec;
        logic [2:0]         mode;
        logic [NUM_W-1:0]   q_cyc;
        logic [NUM_W-1:0]   q_set;
        logic [NUM_W-1:0]   q_act;
        logic [NUM_W-1:0]   q_rec;
        logic               done;
        logic [2:0]         mode_eff;
        logic [SET_W-1:0]   set_cnt;
        logic [4:0]         act_cnt;
        logic [4:0]         rec_cnt;
        logic [1:0]         code;
        logic [7:0]         tbyte;
    } calc_t;

    calc_t q, d;

    logic signed [TIME_W+1:0] rec_diff;
    logic [TIME_W-1:0]        rec_ns;
    logic [NUM_W-1:0]         div_num;
    logic                     div_valid;
    logic [NUM_W-1:0]         div_quot;

    logic [SET_W-1:0]         lim_set;
    logic [4:0]               lim_act;
    logic [4:0]               lim_rec;
    logic [SET_W-1:0]         pk_set;
    logic [4:0]               pk_act;
    logic [4:0]               pk_rec;
    logic [1:0]               pk_code;
    logic [7:0]               pk_byte;

    // Recovery time in ns, floored at zero.
    always_comb begin
        rec_diff = $signed({2'b00, q.cyc_ns}) - $signed({2'b00, q.set_ns})
                 - $signed({2'b00, q.act_ns});
        rec_ns   = (rec_diff < 0) ? '0 : rec_diff[TIME_W-1:0];
    end

    always_comb begin
        case (q.slot)
            SLOT_CYC: div_num = {{EXT_W{1'b0}}, q.cyc_ns};
            SLOT_SET: div_num = {{EXT_W{1'b0}}, q.set_ns};
            SLOT_ACT: div_num = {{EXT_W{1'b0}}, q.act_ns};
            default:  div_num = {{EXT_W{1'b0}}, rec_ns};
        endcase
    end

    pio_ceil_div #(
        .NUM_W (NUM_W),
        .DEN_W (CLK_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.go),
        .num   (div_num),
        .den   (q.per),
        .valid (div_valid),
        .quot  (div_quot)
    );

    pio_count_limits #(
        .Q_W   (NUM_W),
        .SET_W (SET_W)
    ) u_lim (
        .cyc_q   (q.q_cyc),
        .set_q   (q.q_set),
        .act_q   (q.q_act),
        .rec_q   (q.q_rec),
        .rev_hi  (q.rev_hi),
        .set_fin (lim_set),
        .act_fin (lim_act),
        .rec_fin (lim_rec)
    );

    pio_count_pack #(
        .SET_W (SET_W)
    ) u_pack (
        .own_set  (lim_set),
        .own_act  (lim_act),
        .own_rec  (lim_rec),
        .mrg      (q.mrg),
        .mate_set (q.m_set),
        .mate_act (q.m_act),
        .mate_rec (q.m_rec),
        .set_out  (pk_set),
        .act_out  (pk_act),
        .rec_out  (pk_rec),
        .code_out (pk_code),
        .byte_out (pk_byte)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.set_ns = setup_ns;
                    d.act_ns = active_ns;
                    d.cyc_ns = cycle_ns;
                    d.per    = clk_period_ns;
                    d.rev_hi = chip_rev[1];
                    d.mrg    = merge_en;
                    d.m_set  = mate_setup;
                    d.m_act  = mate_active;
                    d.m_rec  = mate_recovery;
                    d.mode   = mode_req;
                    d.slot   = SLOT_CYC;
                    d.go     = 1'b1;
                    d.state  = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_valid) begin
                    case (q.slot)
                        SLOT_CYC: d.q_cyc = div_quot;
                        SLOT_SET: d.q_set = div_quot;
                        SLOT_ACT: d.q_act = div_quot;
                        default:  d.q_rec = div_quot;
                    endcase
                    if (q.slot == SLOT_REC) begin
                        d.state = ST_FIN;
                    end else begin
                        d.slot = q.slot + 2'd1;
                        d.go   = 1'b1;
                    end
                end
            end
            ST_FIN: begin
                d.set_cnt  = pk_set;
                d.act_cnt  = pk_act;
                d.rec_cnt  = pk_rec;
                d.code     = pk_code;
                d.tbyte    = pk_byte;
                d.mode_eff = (q.mode > 3'(MODE_TOP)) ? 3'(MODE_TOP) : q.mode;
                d.done     = 1'b1;
                d.state    = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy         = (q.state != ST_IDLE);
    assign done         = q.done;
    assign mode_eff     = q.mode_eff;
    assign setup_cnt    = q.set_cnt;
    assign active_cnt   = q.act_cnt;
    assign recovery_cnt = q.rec_cnt;
    assign setup_code   = q.code;
    assign timing_byte  = q.tbyte;

endmodule

// File: rtl/pio_count_calc_chk.sv
module pio_count_calc_chk #(
    parameter int CLK_W = 8,
    parameter int SET_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CLK_W-1:0] clk_period_ns,
    input logic [2:0]       mode_eff,
    input logic [SET_W-1:0] setup_cnt,
    input logic [4:0]       active_cnt,
    input logic [4:0]       recovery_cnt,
    input logic [1:0]       setup_code,
    input logic [7:0]       timing_byte
);

    // Input assumption: a usable clock period whenever a request is taken.
    a_in_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (clk_period_ns != '0));

    // R1: accepted request makes the block busy on the next cycle.
    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R1: done is a single-cycle pulse.
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3 / R5: final active count within the generator range.
    a_r5_active_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (active_cnt >= 5'd2 && active_cnt <= 5'd16));

    // R6: final recovery count within the generator range.
    a_r6_recovery_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (recovery_cnt >= 5'd1 && recovery_cnt <= 5'd16));

    // R8: a setup count of three selects the middle code.
    a_r8_code_three: assert property (@(posedge clk) disable iff (!rst_n)
        (done && setup_cnt == SET_W'(3)) |-> (setup_code == 2'b10));

    // R10: clamped mode never exceeds five.
    a_r10_mode_top: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_eff <= 3'd5));

    // R11: packed outputs move only together with done.
    a_r11_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(timing_byte) && $stable(setup_code)));

endmodule

bind pio_count_calc pio_count_calc_chk #(
    .CLK_W (CLK_W),
    .SET_W (SET_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .clk_period_ns (clk_period_ns),
    .mode_eff      (mode_eff),
    .setup_cnt     (setup_cnt),
    .active_cnt    (active_cnt),
    .recovery_cnt  (recovery_cnt),
    .setup_code    (setup_code),
    .timing_byte   (timing_byte)
);

// File: tb/tb_pio_count_calc.sv
`timescale 1ns/1ps
module tb_pio_count_calc;

    localparam int TIME_W = 11;
    localparam int CLK_W  = 8;
    localparam int SET_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        mode_req = '0;
    logic [TIME_W-1:0] setup_ns = '0;
    logic [TIME_W-1:0] active_ns = '0;
    logic [TIME_W-1:0] cycle_ns = '0;
    logic [CLK_W-1:0]  clk_period_ns = 8'd30;
    logic [1:0]        chip_rev = '0;
    logic              merge_en = 1'b0;
    logic [SET_W-1:0]  mate_setup = '0;
    logic [4:0]        mate_active = 5'd1;
    logic [4:0]        mate_recovery = 5'd1;
    logic              busy, done;
    logic [2:0]        mode_eff;
    logic [SET_W-1:0]  setup_cnt;
    logic [4:0]        active_cnt, recovery_cnt;
    logic [1:0]        setup_code;
    logic [7:0]        timing_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pio_count_calc #(.TIME_W(TIME_W), .CLK_W(CLK_W), .SET_W(SET_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_req(mode_req),
        .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
        .clk_period_ns(clk_period_ns), .chip_rev(chip_rev), .merge_en(merge_en),
        .mate_setup(mate_setup), .mate_active(mate_active), .mate_recovery(mate_recovery),
        .busy(busy), .done(done), .mode_eff(mode_eff), .setup_cnt(setup_cnt),
        .active_cnt(active_cnt), .recovery_cnt(recovery_cnt),
        .setup_code(setup_code), .timing_byte(timing_byte)
    );

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ceil_div(input int t, input int p);
        return (t + p - 1) / p;
    endfunction

    task automatic model(input int s_ns, input int a_ns, input int c_ns, input int per,
                         input int rev, input bit mrg, input int ms, input int ma,
                         input int mr, input int mode,
                         output int es, output int ea, output int er,
                         output int ecode, output int ebyte, output int emode);
        int rt, cyc, gap;
        rt = c_ns - (s_ns + a_ns);
        if (rt < 0) rt = 0;
        cyc = ceil_div(c_ns, per);
        es  = ceil_div(s_ns, per);
        ea  = ceil_div(a_ns, per);
        if (ea < 2) ea = 2;
        er  = ceil_div(rt, per);
        gap = cyc - es - ea;
        if (gap < 0) gap = 0;
        if (gap > er) er = gap;
        if (er < 2) er = 2;
        if (er > 17) begin
            ea = ea + er - 17;
            er = 17;
        end
        if (ea > 16) ea = 16;
        if (rev > 1) er = er - 1;
        if (er > 16) er = 16;
        if (es > 15) es = 15;
        if (mrg) begin
            if (ms > es) es = ms;
            if (ma > ea) ea = ma;
            if (mr > er) er = mr;
        end
        case (es)
            1, 2:    ecode = 1;
            3:       ecode = 2;
            4:       ecode = 0;
            default: ecode = 3;
        endcase
        ebyte = ((ea % 16) << 4) | (er % 16);
        emode = (mode > 5) ? 5 : mode;
    endtask

    task automatic run_calc(input int s_ns, input int a_ns, input int c_ns, input int per,
                            input int rev, input bit mrg, input int ms, input int ma,
                            input int mr, input int mode, input bit poke);
        int es, ea, er, ecode, ebyte, emode, waited;
        model(s_ns, a_ns, c_ns, per, rev, mrg, ms, ma, mr, mode,
              es, ea, er, ecode, ebyte, emode);
        @(negedge clk);
        setup_ns = TIME_W'(s_ns); active_ns = TIME_W'(a_ns); cycle_ns = TIME_W'(c_ns);
        clk_period_ns = CLK_W'(per); chip_rev = 2'(rev); merge_en = mrg;
        mate_setup = SET_W'(ms); mate_active = 5'(ma); mate_recovery = 5'(mr);
        mode_req = 3'(mode);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(int'(busy), 1, "R1 busy after start");
        if (poke) begin
            // R1: a second request with other inputs while busy must be ignored.
            repeat (5) @(negedge clk);
            setup_ns = 11'd1000; active_ns = 11'd3; cycle_ns = 11'd2000;
            clk_period_ns = 8'd1; chip_rev = ~chip_rev; merge_en = ~mrg; mode_req = 3'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        check(int'(done), 1, "R1 done reached");
        check(int'(setup_cnt), es, "R2/R7 setup_cnt");
        check(int'(active_cnt), ea, "R3/R5 active_cnt");
        check(int'(recovery_cnt), er, "R4/R6 recovery_cnt");
        check(int'(setup_code), ecode, "R8 setup_code");
        check(int'(timing_byte), ebyte, "R9 timing_byte");
        check(int'(mode_eff), emode, "R10 mode_eff");
        @(negedge clk);
        check(int'(done), 0, "R1 done single cycle");
        check(int'(busy), 0, "R1 idle after done");
        check(int'(timing_byte), ebyte, "R11 outputs hold");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(int'(busy), 0, "R11 busy at reset");
        check(int'(done), 0, "R11 done at reset");
        check(int'(timing_byte), 0, "R11 timing_byte at reset");
        check(int'(setup_cnt), 0, "R11 setup_cnt at reset");
        check(int'(setup_code), 0, "R11 setup_code at reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed corner cases.
        run_calc(70, 165, 600, 30, 1, 0, 0, 1, 1, 0, 0);     // R3 R4 typical: byte 0x6D
        run_calc(10, 10, 1000, 10, 0, 0, 0, 1, 1, 1, 0);     // R5 spill into active
        run_calc(10, 10, 1000, 10, 3, 0, 0, 1, 1, 2, 0);     // R5 R6 spill with revision offset
        run_calc(70, 165, 100, 30, 2, 0, 0, 1, 1, 3, 0);     // R4 negative recovery time, R6 rev
        run_calc(0, 0, 0, 7, 0, 0, 0, 1, 1, 4, 0);           // R2 R3 zero times, R8 code 11
        run_calc(30, 60, 240, 30, 0, 0, 0, 1, 1, 6, 0);      // R8 setup 1, R10 clamp
        run_calc(60, 60, 240, 30, 0, 0, 0, 1, 1, 7, 0);      // R8 setup 2
        run_calc(90, 60, 300, 30, 0, 0, 0, 1, 1, 5, 0);      // R8 setup 3
        run_calc(120, 60, 300, 30, 0, 0, 0, 1, 1, 5, 0);     // R8 setup 4
        run_calc(150, 60, 400, 30, 0, 0, 0, 1, 1, 5, 0);     // R8 setup 5
        run_calc(2000, 30, 2047, 1, 0, 0, 0, 1, 1, 0, 0);    // R2 setup saturation
        run_calc(30, 480, 600, 30, 0, 0, 0, 1, 1, 0, 0);     // R9 active 16 nibble 0
        run_calc(30, 60, 200, 30, 0, 1, 4, 9, 12, 0, 0);     // R7 merge, partner slower
        run_calc(200, 400, 1500, 20, 1, 1, 2, 3, 4, 0, 0);   // R7 merge, own slower
        run_calc(70, 165, 600, 30, 1, 0, 0, 1, 1, 2, 1);     // R1 start while busy ignored

        // Constrained random.
        for (int i = 0; i < 300; i++) begin
            int s, a, c, p, rv, ms, ma, mr, md;
            bit mg, pk;
            s  = $urandom_range(0, 400);
            a  = $urandom_range(0, 700);
            c  = $urandom_range(0, 2047);
            p  = $urandom_range(1, 60);
            rv = $urandom_range(0, 3);
            mg = 1'($urandom_range(0, 1));
            ms = $urandom_range(0, 15);
            ma = $urandom_range(1, 16);
            mr = $urandom_range(1, 16);
            md = $urandom_range(0, 7);
            pk = ($urandom_range(0, 7) == 0);
            run_calc(s, a, c, p, rv, mg, ms, ma, mr, md, pk);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule